// File: doc/BRIEF.md
# Set/Clear Status Flag Register

This block holds the mode and error state of a serial controller as a set of individual flags. Software does not change these flags with read-modify-write. Each writable flag instead has a dedicated set bit and a dedicated clear bit in a write-only command word. A 1 in one of these bits acts on its own flag, and a 0 leaves that flag alone. This means two agents can update different flags without interfering with each other.

The status word can be read at any time. It holds:
- an enable flag: cleared means configuration mode, set means operational;
- a master-select flag;
- six sticky error flags;
- a live busy indication.

The datapath reports error events through pulse inputs. Five of those sources are each gated by their own enable bit. An error interrupt stays asserted while any error flag is set.

Top module: `status_flag_reg`

## Requirements
- R1: After reset, all flags are 0, the status word is 0 apart from bit 13, and `err_irq` is 0.
- R2: Status bit positions are fixed:
  - enable = bit 0, master-select = bit 1;
  - mode error = bit 7, transmit overflow = bit 8, receive overflow = bit 9, abort = bit 10;
  - transmit underflow = bit 11, receive underflow = bit 12, busy = bit 13;
  - all other bits read 0.
- R3: A command write with a set bit at 1 and its paired clear bit at 0 makes that flag 1 from the next clock edge. No other flag changes. The set bits are:
  - set enable = bit 1, set master-select = bit 3, set receive underflow = bit 5, set mode error = bit 7;
  - bits 12, 13, 14 and 15 set transmit overflow, receive overflow, abort and transmit underflow, in that order.
- R4: A command write with a clear bit at 1 and its paired set bit at 0 makes that flag 0 from the next clock edge. Command bits at 0 have no effect. The clear bits are:
  - clear enable = bit 0, clear master-select = bit 2, clear receive underflow = bit 4, clear mode error = bit 6;
  - bits 8, 9, 10 and 11 clear transmit overflow, receive overflow, abort and transmit underflow, in that order.
- R5: If a flag's set bit and clear bit are both 1 in the same write, that flag keeps its value.
- R6: A hardware event pulse `hw_err` sets its flag on the next edge only when its enable `err_en` is 1.
  - `hw_err` bit order: [0] mode error, [1] transmit overflow, [2] receive overflow, [3] abort, [4] transmit underflow, [5] receive underflow.
  - `err_en` bit order: [0] transmit overflow, [1] receive overflow, [2] abort, [3] transmit underflow, [4] receive underflow.
  - The mode error event is never gated.
- R7: An enabled hardware event in the same cycle as a software clear of that flag wins, so the flag stays 1.
- R8: `err_irq` is 1 exactly while at least one of the six error flags is 1. Enable, master-select and busy do not affect it.
- R9: A single write can set master-select and clear all six error flags at the same time, for example the command 0x0F58.
- R10: Status bit 13 follows `busy_in` in the same cycle, with no clock edge needed.
- R11: With `cmd_we` at 0, `cmd_data` has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_data | input | 16 | Paired set/clear command bits |
| err_en | input | 5 | Per-source hardware error enables |
| hw_err | input | 6 | Hardware error event pulses |
| busy_in | input | 1 | Live busy indication from the datapath |
| status | output | 16 | Status word |
| err_irq | output | 1 | Error interrupt |

## Verification
The hardest situation to reach is a datapath event that lands in exactly the cycle where software clears the same flag. The stimulus produces it by setting up the event pulse and the clear command on the same falling edge, so both are captured by a single rising edge. Conflicting set/clear pairs, and events whose enable is low, are driven the same way. The flags are then read back from the status word to show that nothing moved.

// File: rtl/status_flag_reg.sv
module status_flag_reg #(
  parameter int CMD_W = 16,
  parameter int NFLAG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic [4:0]       err_en,
  input  logic [5:0]       hw_err,
  input  logic             busy_in,
  output logic [15:0]      status,
  output logic             err_irq
);
  // flag order: 0 en, 1 ms, 2 me, 3 te, 4 re, 5 ae, 6 tue, 7 rue
  logic [NFLAG-1:0] f_q, set_v, clr_v, hw_v, nxt;

  assign set_v = cmd_we ? {cmd_data[5], cmd_data[15], cmd_data[14], cmd_data[13],
                           cmd_data[12], cmd_data[7], cmd_data[3], cmd_data[1]} : '0;
  assign clr_v = cmd_we ? {cmd_data[4], cmd_data[11], cmd_data[10], cmd_data[9],
                           cmd_data[8], cmd_data[6], cmd_data[2], cmd_data[0]} : '0;
  assign hw_v  = {hw_err[5] & err_en[4], hw_err[4] & err_en[3], hw_err[3] & err_en[2],
                  hw_err[2] & err_en[1], hw_err[1] & err_en[0], hw_err[0], 2'b00};

  assign nxt = hw_v | (set_v & ~clr_v) | (f_q & ~(clr_v & ~set_v));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= nxt;
  end

  assign status  = {2'b00, busy_in, f_q[7:2], 5'b00000, f_q[1:0]};
  assign err_irq = |f_q[7:2];
endmodule

module status_flag_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [15:0] cmd_data,
  input logic [4:0]  err_en,
  input logic [5:0]  hw_err,
  input logic [15:0] status,
  input logic        err_irq
);
  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_data[1] && !cmd_data[0] |=> status[0]);
  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_data[0] && !cmd_data[1] |=> !status[0]);
  // R5
  ms_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_data[2] && cmd_data[3] |=> $stable(status[1]));
  // R7
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err[1] && err_en[0] |=> status[8]);
  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_irq) |-> $past(cmd_we));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we && hw_err == 6'd0 |=> $stable(status[12:0]));
endmodule

bind status_flag_reg status_flag_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
  .err_en(err_en), .hw_err(hw_err), .status(status), .err_irq(err_irq)
);

// File: tb/status_flag_reg_bench.sv
module status_flag_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_data = '0;
  logic [4:0]  err_en = '0;
  logic [5:0]  hw_err = '0;
  logic        busy_in = 1'b0;
  logic [15:0] status;
  logic        err_irq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_reg u_status_flag_reg (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .err_en(err_en), .hw_err(hw_err), .busy_in(busy_in),
    .status(status), .err_irq(err_irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  // apply one cycle of stimulus at a falling edge, observe at the next falling edge
  task automatic step(input logic we, input logic [15:0] d, input logic [5:0] ev);
    cmd_we = we; cmd_data = d; hw_err = ev;
    @(negedge clk);
    cmd_we = 1'b0; cmd_data = '0; hw_err = '0;
  endtask

  task automatic t_reset;
    chk("R1 status", status, 16'h0000);
    chk("R1 irq", {15'd0, err_irq}, 16'd0);
  endtask

  task automatic t_mode_bits;
    step(1, 16'h0002, 0); chk("R3 set enable", status, 16'h0001);
    step(1, 16'h0008, 0); chk("R3 set ms", status, 16'h0003);
    step(1, 16'h0001, 0); chk("R4 clear enable", status, 16'h0002);
    step(1, 16'h0000, 0); chk("R4 zero write", status, 16'h0002);
    chk("R8 no irq from mode bits", {15'd0, err_irq}, 16'd0);
  endtask

  task automatic t_sw_errors;
    step(1, 16'h1000, 0); chk("R3 set te only", status, 16'h0102);
    step(1, 16'hE0A0, 0); chk("R2 R3 all errors", status, 16'h1F82);
    chk("R8 irq on", {15'd0, err_irq}, 16'd1);
    step(1, 16'h0100, 0); chk("R4 clear te only", status, 16'h1E82);
    step(1, 16'h0E50, 0); chk("R4 clear rest", status, 16'h0002);
    chk("R8 irq off", {15'd0, err_irq}, 16'd0);
  endtask

  task automatic t_conflict;
    step(1, 16'h000C, 0); chk("R5 ms both", status, 16'h0002);
    step(1, 16'h1100, 0); chk("R5 te both", status, 16'h0002);
    step(1, 16'h0030, 0); chk("R5 rue both", status, 16'h0002);
  endtask

  task automatic t_hw;
    err_en = 5'b00000;
    step(0, 0, 6'b111110); chk("R6 gated off", status, 16'h0002);
    chk("R6 no irq", {15'd0, err_irq}, 16'd0);
    step(0, 0, 6'b000001); chk("R6 mode ungated", status, 16'h0082);
    err_en = 5'b00100;
    step(0, 0, 6'b001000); chk("R6 abort enabled", status, 16'h0482);
    err_en = 5'b11111;
    step(0, 0, 6'b110110); chk("R6 all enabled", status, 16'h1F82);
    step(1, 16'h0F50, 0); chk("R4 clear all", status, 16'h0002);
  endtask

  task automatic t_race;
    err_en = 5'b11111;
    step(1, 16'h0100, 6'b000010); chk("R7 event beats clear", status, 16'h0102);
    err_en = 5'b00000;
    step(1, 16'h0100, 6'b000010); chk("R7 gated event loses", status, 16'h0002);
  endtask

  task automatic t_combo;
    step(1, 16'h0004, 0); chk("R4 clear ms", status, 16'h0000);
    step(1, 16'hF0A0, 0); chk("R3 errors set", status, 16'h1F80);
    step(1, 16'h0F58, 0); chk("R9 ms set errors cleared", status, 16'h0002);
    chk("R9 irq cleared", {15'd0, err_irq}, 16'd0);
  endtask

  task automatic t_busy;
    busy_in = 1'b1; #1;
    chk("R10 busy follows", status, 16'h2002);
    chk("R8 busy no irq", {15'd0, err_irq}, 16'd0);
    busy_in = 1'b0; #1;
    chk("R10 busy drops", status, 16'h0002);
  endtask

  task automatic t_no_we;
    step(0, 16'hFFFF, 0); chk("R11 strobe low", status, 16'h0002);
    step(0, 16'h0003, 0); chk("R11 strobe low 2", status, 16'h0002);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_bits();
    t_sw_errors();
    t_conflict();
    t_hw();
    t_race();
    t_combo();
    t_busy();
    t_no_we();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule